// File: doc/BRIEF.md
# Bus-Matching Width Converter

This block sits between a 36-bit word interface (side A) and a bus of selectable width (side B). In the A-to-B direction it takes one 36-bit word and hands it out on side B as one, two or four beats. In the B-to-A direction it collects beats from side B and delivers each complete 36-bit word to side A. Every one of the four streams uses a valid/ready handshake.

Three inputs select the side-B format. A bus-match input chooses between the full 36-bit width and a narrow bus. A size input then chooses between 9-bit and 18-bit beats. An endian choice sets which part of the word travels first. The block samples the endian choice while reset is held and keeps it until the next reset. The same beat order applies in both directions. Storage and clock-domain crossing belong to the surrounding logic.

Top module: `bus_matcher`

## Requirements
- R1: With `bus_match_i` low, side B carries the whole 36-bit word as a single beat in both directions. A word accepted on side A appears on `b_rd_data_o` in the next cycle.
- R2: With `bus_match_i` high, `size_i` high selects byte mode and `size_i` low selects word mode. Byte mode uses four 9-bit beats on bits [8:0] of side B. Word mode uses two 18-bit beats on bits [17:0].
- R3: In the narrow modes, the unused upper bits of `b_rd_data_o` are driven to zero. The unused upper bits of `b_wr_data_i` have no effect on the assembled word.
- R4: `big_endian_i` is sampled on clock edges while `rst_ni` is low. A change on `big_endian_i` after reset has no effect on beat order.
- R5: When splitting a word, big-endian sends the most significant lane first (byte mode: bits [35:27]) and little-endian sends the least significant lane first (bits [8:0]).
- R6: When assembling a word, the first beat received fills the most significant lane under big-endian and the least significant lane under little-endian.
- R7: An assembled word is offered on side A only after the final beat of that word has been accepted. `a_rd_valid_o` stays low while the word is incomplete.
- R8: Reset discards a partly assembled word and a partly sent word. The next word after reset starts at its first beat.
- R9: A valid output whose ready input is low keeps its valid high and its data unchanged until the transfer completes.
- R10: The beat counters advance only on completed handshakes. Idle cycles on either side neither skip nor repeat beats.
- R11: Right after reset, `b_rd_valid_o` and `a_rd_valid_o` are low, and `a_wr_ready_o` and `b_wr_ready_o` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; endian sampled while low |
| bus_match_i | input | 1 | High: narrow side-B bus; low: full 36-bit width |
| size_i | input | 1 | In narrow mode: high byte beats, low word beats |
| big_endian_i | input | 1 | Beat order, sampled during reset: high most significant first |
| a_wr_valid_i | input | 1 | Side-A word offered for splitting |
| a_wr_data_i | input | 36 | Side-A word to split |
| a_wr_ready_o | output | 1 | Splitter can take a word |
| b_rd_valid_o | output | 1 | Side-B beat available |
| b_rd_data_o | output | 36 | Side-B beat, zero-extended in narrow modes |
| b_rd_ready_i | input | 1 | Side-B consumer takes the beat |
| b_wr_valid_i | input | 1 | Side-B beat offered for assembly |
| b_wr_data_i | input | 36 | Side-B beat, low bits used in narrow modes |
| b_wr_ready_o | output | 1 | Assembler can take a beat |
| a_rd_valid_o | output | 1 | Assembled word available on side A |
| a_rd_data_o | output | 36 | Assembled word |
| a_rd_ready_i | input | 1 | Side-A consumer takes the word |

## Verification
The hardest state to reach is a word abandoned partway. This covers an assembler holding some but not all beats of a word, and a splitter left between beats. The bench feeds two byte beats, or takes one beat of a split word, and then asserts reset. The following full word must come out with the correct lanes. A stale counter would shift every lane, so the data compare reveals it. Endian latching is tested the same way: the endian input is flipped after reset, and the order must stay as it was.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [1:0] {
    MODE_LONG = 2'd0,
    MODE_WORD = 2'd1,
    MODE_BYTE = 2'd2
  } bm_mode_e;
endpackage

// File: rtl/bm_cfg.sv
module bm_cfg
  import bm_pkg::*;
#(
  parameter  int LANES = 4,
  localparam int CW    = $clog2(LANES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_match_i,
  input  logic          size_i,
  input  logic          big_endian_i,
  output bm_mode_e      mode_o,
  output logic          big_o,
  output logic [CW-1:0] last_o
);
  logic big_q;

  // sampled only while reset is held, frozen afterwards
  always_ff @(posedge clk_i) begin
    if (!rst_ni) big_q <= big_endian_i;
  end

  always_comb begin
    if (!bus_match_i) begin
      mode_o = MODE_LONG;
      last_o = '0;
    end else if (size_i) begin
      mode_o = MODE_BYTE;
      last_o = CW'(LANES - 1);
    end else begin
      mode_o = MODE_WORD;
      last_o = CW'(LANES / 2 - 1);
    end
  end

  assign big_o = big_q;
endmodule

// File: rtl/bm_beat_ctr.sv
module bm_beat_ctr #(
  parameter  int LANES = 4,
  localparam int CW    = $clog2(LANES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic [CW-1:0] last_i,
  input  logic          big_i,
  output logic          at_last_o,
  output logic [CW-1:0] lane_o
);
  logic [CW-1:0] cnt_q;

  assign at_last_o = (cnt_q == last_i);
  assign lane_o    = big_i ? (last_i - cnt_q) : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (adv_i)     cnt_q <= at_last_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/bm_lane_sel.sv
module bm_lane_sel
  import bm_pkg::*;
#(
  parameter  int BEAT_W = 9,
  parameter  int LANES  = 4,
  localparam int W      = BEAT_W * LANES,
  localparam int CW     = $clog2(LANES),
  localparam int NW     = LANES / 2
) (
  input  logic [W-1:0]  word_i,
  input  bm_mode_e      mode_i,
  input  logic [CW-1:0] lane_i,
  output logic [W-1:0]  beat_o
);
  logic [BEAT_W-1:0]   byte_l [LANES];
  logic [2*BEAT_W-1:0] word_l [NW];

  for (genvar g = 0; g < LANES; g++) begin : g_byte
    assign byte_l[g] = word_i[g*BEAT_W +: BEAT_W];
  end
  for (genvar g = 0; g < NW; g++) begin : g_word
    assign word_l[g] = word_i[g*2*BEAT_W +: 2*BEAT_W];
  end

  always_comb begin
    beat_o = '0;
    unique case (mode_i)
      MODE_LONG: beat_o = word_i;
      MODE_WORD: beat_o[2*BEAT_W-1:0] = word_l[lane_i[CW-2:0]];
      MODE_BYTE: beat_o[BEAT_W-1:0]   = byte_l[lane_i];
      default:   beat_o = '0;
    endcase
  end
endmodule

// File: rtl/bm_lane_ins.sv
module bm_lane_ins
  import bm_pkg::*;
#(
  parameter  int BEAT_W = 9,
  parameter  int LANES  = 4,
  localparam int W      = BEAT_W * LANES,
  localparam int CW     = $clog2(LANES)
) (
  input  logic [W-1:0]  acc_i,
  input  logic [W-1:0]  beat_i,
  input  bm_mode_e      mode_i,
  input  logic [CW-1:0] lane_i,
  output logic [W-1:0]  acc_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int HALF = g % 2;
    logic [BEAT_W-1:0] old_l, nxt_l;
    assign old_l = acc_i[g*BEAT_W +: BEAT_W];
    always_comb begin
      unique case (mode_i)
        MODE_LONG: nxt_l = beat_i[g*BEAT_W +: BEAT_W];
        MODE_WORD: nxt_l = (lane_i == CW'(g / 2)) ? beat_i[HALF*BEAT_W +: BEAT_W] : old_l;
        MODE_BYTE: nxt_l = (lane_i == CW'(g)) ? beat_i[BEAT_W-1:0] : old_l;
        default:   nxt_l = old_l;
      endcase
    end
    assign acc_o[g*BEAT_W +: BEAT_W] = nxt_l;
  end
endmodule

// File: rtl/bm_split.sv
module bm_split
  import bm_pkg::*;
#(
  parameter  int BEAT_W = 9,
  parameter  int LANES  = 4,
  localparam int W      = BEAT_W * LANES,
  localparam int CW     = $clog2(LANES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bm_mode_e      mode_i,
  input  logic          big_i,
  input  logic [CW-1:0] last_i,
  input  logic          w_valid_i,
  input  logic [W-1:0]  w_data_i,
  output logic          w_ready_o,
  output logic          n_valid_o,
  output logic [W-1:0]  n_data_o,
  input  logic          n_ready_i
);
  logic          full_q;
  logic [W-1:0]  hold_q;
  logic          n_fire, w_fire, at_last;
  logic [CW-1:0] lane;

  assign n_fire    = full_q && n_ready_i;
  // take the next word in the same cycle the last beat leaves
  assign w_ready_o = !full_q || (n_fire && at_last);
  assign w_fire    = w_valid_i && w_ready_o;
  assign n_valid_o = full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else if (w_fire) begin
      full_q <= 1'b1;
      hold_q <= w_data_i;
    end else if (n_fire && at_last) begin
      full_q <= 1'b0;
    end
  end

  bm_beat_ctr #(.LANES(LANES)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (w_fire),
    .adv_i     (n_fire),
    .last_i    (last_i),
    .big_i     (big_i),
    .at_last_o (at_last),
    .lane_o    (lane)
  );

  bm_lane_sel #(.BEAT_W(BEAT_W), .LANES(LANES)) u_sel (
    .word_i (hold_q),
    .mode_i (mode_i),
    .lane_i (lane),
    .beat_o (n_data_o)
  );
endmodule

// File: rtl/bm_pack.sv
module bm_pack
  import bm_pkg::*;
#(
  parameter  int BEAT_W = 9,
  parameter  int LANES  = 4,
  localparam int W      = BEAT_W * LANES,
  localparam int CW     = $clog2(LANES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bm_mode_e      mode_i,
  input  logic          big_i,
  input  logic [CW-1:0] last_i,
  input  logic          n_valid_i,
  input  logic [W-1:0]  n_data_i,
  output logic          n_ready_o,
  output logic          w_valid_o,
  output logic [W-1:0]  w_data_o,
  input  logic          w_ready_i
);
  logic          done_q;
  logic [W-1:0]  acc_q, acc_nxt;
  logic          n_fire, at_last;
  logic [CW-1:0] lane;

  // accumulator doubles as output register: beats enter only once it is free
  assign n_ready_o = !done_q || w_ready_i;
  assign n_fire    = n_valid_i && n_ready_o;
  assign w_valid_o = done_q;
  assign w_data_o  = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      acc_q  <= '0;
    end else if (n_fire) begin
      acc_q  <= acc_nxt;
      done_q <= at_last;
    end else if (done_q && w_ready_i) begin
      done_q <= 1'b0;
    end
  end

  bm_beat_ctr #(.LANES(LANES)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (1'b0),
    .adv_i     (n_fire),
    .last_i    (last_i),
    .big_i     (big_i),
    .at_last_o (at_last),
    .lane_o    (lane)
  );

  bm_lane_ins #(.BEAT_W(BEAT_W), .LANES(LANES)) u_ins (
    .acc_i  (acc_q),
    .beat_i (n_data_i),
    .mode_i (mode_i),
    .lane_i (lane),
    .acc_o  (acc_nxt)
  );
endmodule

// File: rtl/bus_matcher.sv
module bus_matcher
  import bm_pkg::*;
#(
  parameter  int BEAT_W = 9,
  parameter  int LANES  = 4,
  localparam int W      = BEAT_W * LANES,
  localparam int CW     = $clog2(LANES)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bus_match_i,
  input  logic         size_i,
  input  logic         big_endian_i,
  input  logic         a_wr_valid_i,
  input  logic [W-1:0] a_wr_data_i,
  output logic         a_wr_ready_o,
  output logic         b_rd_valid_o,
  output logic [W-1:0] b_rd_data_o,
  input  logic         b_rd_ready_i,
  input  logic         b_wr_valid_i,
  input  logic [W-1:0] b_wr_data_i,
  output logic         b_wr_ready_o,
  output logic         a_rd_valid_o,
  output logic [W-1:0] a_rd_data_o,
  input  logic         a_rd_ready_i
);
  bm_mode_e      mode;
  logic          big;
  logic [CW-1:0] last;

  bm_cfg #(.LANES(LANES)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_match_i  (bus_match_i),
    .size_i       (size_i),
    .big_endian_i (big_endian_i),
    .mode_o       (mode),
    .big_o        (big),
    .last_o       (last)
  );

  bm_split #(.BEAT_W(BEAT_W), .LANES(LANES)) u_split (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .big_i     (big),
    .last_i    (last),
    .w_valid_i (a_wr_valid_i),
    .w_data_i  (a_wr_data_i),
    .w_ready_o (a_wr_ready_o),
    .n_valid_o (b_rd_valid_o),
    .n_data_o  (b_rd_data_o),
    .n_ready_i (b_rd_ready_i)
  );

  bm_pack #(.BEAT_W(BEAT_W), .LANES(LANES)) u_pack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .big_i     (big),
    .last_i    (last),
    .n_valid_i (b_wr_valid_i),
    .n_data_i  (b_wr_data_i),
    .n_ready_o (b_wr_ready_o),
    .w_valid_o (a_rd_valid_o),
    .w_data_o  (a_rd_data_o),
    .w_ready_i (a_rd_ready_i)
  );
endmodule

// File: rtl/bus_matcher_chk.sv
module bus_matcher_chk #(
  parameter  int BEAT_W = 9,
  parameter  int LANES  = 4,
  localparam int W      = BEAT_W * LANES,
  localparam int CW     = $clog2(LANES)
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         bus_match_i,
  input logic         size_i,
  input logic         a_wr_valid_i,
  input logic [W-1:0] a_wr_data_i,
  input logic         a_wr_ready_o,
  input logic         b_rd_valid_o,
  input logic [W-1:0] b_rd_data_o,
  input logic         b_rd_ready_i,
  input logic         b_wr_valid_i,
  input logic         b_wr_ready_o,
  input logic         a_rd_valid_o,
  input logic [W-1:0] a_rd_data_o,
  input logic         a_rd_ready_i
);
  logic [CW-1:0] last_c, pk_cnt;
  logic          b_fire;

  assign last_c = !bus_match_i ? '0 : (size_i ? CW'(LANES - 1) : CW'(LANES / 2 - 1));
  assign b_fire = b_wr_valid_i && b_wr_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pk_cnt <= '0;
    else if (b_fire) pk_cnt <= (pk_cnt == last_c) ? '0 : pk_cnt + 1'b1;
  end

  a_r9_split_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_rd_valid_o && !b_rd_ready_i |=> b_rd_valid_o && $stable(b_rd_data_o));

  a_r9_pack_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_rd_valid_o && !a_rd_ready_i |=> a_rd_valid_o && $stable(a_rd_data_o));

  a_r1_long_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_match_i && a_wr_valid_i && a_wr_ready_o |=>
      b_rd_valid_o && b_rd_data_o == $past(a_wr_data_i));

  a_r7_no_early_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_fire && pk_cnt != last_c |=> !a_rd_valid_o);

  a_r7_release_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_fire && pk_cnt == last_c |=> a_rd_valid_o);

  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_match_i && size_i && b_rd_valid_o |-> b_rd_data_o[W-1:BEAT_W] == '0);

  a_r11_reset_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !b_rd_valid_o && !a_rd_valid_o);
endmodule

bind bus_matcher bus_matcher_chk #(.BEAT_W(BEAT_W), .LANES(LANES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_match_i  (bus_match_i),
  .size_i       (size_i),
  .a_wr_valid_i (a_wr_valid_i),
  .a_wr_data_i  (a_wr_data_i),
  .a_wr_ready_o (a_wr_ready_o),
  .b_rd_valid_o (b_rd_valid_o),
  .b_rd_data_o  (b_rd_data_o),
  .b_rd_ready_i (b_rd_ready_i),
  .b_wr_valid_i (b_wr_valid_i),
  .b_wr_ready_o (b_wr_ready_o),
  .a_rd_valid_o (a_rd_valid_o),
  .a_rd_data_o  (a_rd_data_o),
  .a_rd_ready_i (a_rd_ready_i)
);

// File: tb/bus_matcher_test.sv
module bus_matcher_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_match_i = 1'b0, size_i = 1'b0, big_endian_i = 1'b0;
  logic        a_wr_valid_i = 1'b0, b_rd_ready_i = 1'b0;
  logic        b_wr_valid_i = 1'b0, a_rd_ready_i = 1'b0;
  logic [35:0] a_wr_data_i = '0, b_wr_data_i = '0;
  logic        a_wr_ready_o, b_rd_valid_o, b_wr_ready_o, a_rd_valid_o;
  logic [35:0] b_rd_data_o, a_rd_data_o;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk_i = ~clk_i;

  bus_matcher uut (.*);

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: cycles %0d expected fewer", 200000);
    finish_run();
  end

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic check(string req, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] lane_mask(int n);
    int bw = 36 / n;
    return (bw == 36) ? '1 : ((36'd1 << bw) - 36'd1);
  endfunction

  function automatic logic [35:0] exp_beat(logic [35:0] w, int n, int k, bit big);
    int bw = 36 / n;
    int lane = big ? (n - 1 - k) : k;
    return (w >> (lane * bw)) & lane_mask(n);
  endfunction

  task automatic do_reset(bit bm, bit sz, bit be);
    rst_ni = 1'b0;
    bus_match_i = bm; size_i = sz; big_endian_i = be;
    a_wr_valid_i = 0; b_rd_ready_i = 0; b_wr_valid_i = 0; a_rd_ready_i = 0;
    repeat (3) step();
    rst_ni = 1'b1;
    check("R11 b_rd_valid", 36'(b_rd_valid_o), 36'd0);
    check("R11 a_rd_valid", 36'(a_rd_valid_o), 36'd0);
    check("R11 a_wr_ready", 36'(a_wr_ready_o), 36'd1);
    check("R11 b_wr_ready", 36'(b_wr_ready_o), 36'd1);
  endtask

  task automatic send_wide(logic [35:0] w);
    a_wr_valid_i = 1'b1;
    a_wr_data_i = w;
    check("R10 a_wr_ready", 36'(a_wr_ready_o), 36'd1);
    step();
    a_wr_valid_i = 1'b0;
  endtask

  // split one word into n beats, optionally stalling the reader before each beat
  task automatic split_test(string req, logic [35:0] w, int n, bit big, bit stall);
    send_wide(w);
    for (int k = 0; k < n; k++) begin
      if (stall) begin
        b_rd_ready_i = 1'b0;
        step(); step();
        check({req, " R9 held valid"}, 36'(b_rd_valid_o), 36'd1);
        check({req, " R9 held data"}, b_rd_data_o, exp_beat(w, n, k, big));
      end
      b_rd_ready_i = 1'b1;
      check({req, " beat valid"}, 36'(b_rd_valid_o), 36'd1);
      check({req, " beat data"}, b_rd_data_o, exp_beat(w, n, k, big));
      step();
    end
    b_rd_ready_i = 1'b0;
    check({req, " drained"}, 36'(b_rd_valid_o), 36'd0);
  endtask

  // feed n beats with junk in unused upper bits, optional bubbles and output stall
  task automatic pack_test(string req, logic [35:0] w, int n, bit big, bit bubble, bit stall);
    a_rd_ready_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (bubble) begin
        b_wr_valid_i = 1'b0;
        b_wr_data_i = '1;
        step();
      end
      b_wr_valid_i = 1'b1;
      b_wr_data_i = exp_beat(w, n, k, big) | ~lane_mask(n);
      check({req, " b_wr_ready"}, 36'(b_wr_ready_o), 36'd1);
      check({req, " R7 not early"}, 36'(a_rd_valid_o), 36'd0);
      step();
    end
    b_wr_valid_i = 1'b0;
    check({req, " word valid"}, 36'(a_rd_valid_o), 36'd1);
    check({req, " word data"}, a_rd_data_o, w);
    if (stall) begin
      step(); step();
      check({req, " R9 word held"}, a_rd_data_o, w);
      check({req, " R9 beat blocked"}, 36'(b_wr_ready_o), 36'd0);
    end
    a_rd_ready_i = 1'b1;
    step();
    a_rd_ready_i = 1'b0;
    check({req, " word taken"}, 36'(a_rd_valid_o), 36'd0);
  endtask

  task automatic t_long();
    do_reset(0, 0, 0);
    split_test("R1 long split", 36'h9_8765_4321, 1, 0, 0);
    pack_test("R1 long pack", 36'hF_EDCB_A987, 1, 0, 0, 0);
  endtask

  task automatic t_byte_little();
    do_reset(1, 1, 0);
    split_test("R2 R3 byte split", 36'h1_2345_6789, 4, 0, 1);
    pack_test("R2 R3 byte pack", 36'hA_5C3B_7E19, 4, 0, 1, 1);
    pack_test("R10 byte pack idle", 36'h0_FEED_BEEF, 4, 0, 1, 0);
  endtask

  task automatic t_word_big();
    do_reset(1, 0, 1);
    split_test("R5 word big split", 36'hC_0FFE_E123, 2, 1, 0);
    pack_test("R6 word big pack", 36'h3_1415_9265, 2, 1, 0, 1);
    do_reset(1, 0, 0);
    split_test("R2 word little split", 36'h8_0000_FFFF, 2, 0, 1);
  endtask

  task automatic t_latch();
    do_reset(1, 1, 1);
    big_endian_i = 1'b0;
    step();
    split_test("R4 R5 byte big split", 36'h7_6543_210F, 4, 1, 0);
    pack_test("R4 R6 byte big pack", 36'h2_7182_8182, 4, 1, 1, 0);
  endtask

  task automatic t_abort();
    do_reset(1, 1, 0);
    b_wr_valid_i = 1'b1;
    b_wr_data_i = 36'h0_0000_01AB;
    step(); step();
    b_wr_valid_i = 1'b0;
    send_wide(36'h5_5555_5555);
    b_rd_ready_i = 1'b1;
    step();
    b_rd_ready_i = 1'b0;
    do_reset(1, 1, 0);
    pack_test("R8 pack after abort", 36'h6_9A4C_1D2E, 4, 0, 0, 0);
    split_test("R8 split after abort", 36'hB_1234_5678, 4, 0, 0);
  endtask

  initial begin
    t_long();
    t_byte_little();
    t_word_big();
    t_latch();
    t_abort();
    finish_run();
  end
endmodule